// File: doc/BRIEF.md
# Vector Element Loop Sequencer

This block turns one vector instruction into a stream of per-element issue slots. On a start pulse it decodes a 5-bit per-instruction mode word, with the result-flag bit alongside it, into one of four mode classes: simple, reduce, saturate and fail-first. It latches the decoded flags, the predicate mask and the scalar-destination flag. It then walks an element index across the vector length at one element per cycle, either upwards or downwards. For each element it either issues it, issues it as a zero-write, or skips it. When the loop is over it raises a one-cycle done pulse. The arithmetic, saturation clamping and the fail-first truncation decision are made elsewhere. An external unit that decides to truncate raises the stop request, and the loop ends after the element that is currently presented.

The controller has three states. IDLE waits for a start pulse. On start it goes to RUN, or goes straight to DONE when the length is zero or the mode word is the reserved code. RUN presents one element per cycle and stays there while elements remain. It leaves for DONE on the last element, on a stop request, or after the first issued element when the destination is scalar outside reduce mode. DONE lasts exactly one cycle and always returns to IDLE. A start pulse outside IDLE has no effect.

Mode word layout (bit 4 is the most significant bit). Bits [4:3] = 00 with bit 2 = 0 is simple mode. Bits [4:3] = 00 with bit 2 = 1 is reduce mode. Bits [4:3] = 10 is saturate mode. Bit 3 = 1 is fail-first mode.

Top module: `vec_elem_seq`

## Requirements
- R1: Mode word 00,0,d,s decodes to class code 0 (simple), with dz_o = bit 1 and sz_o = bit 0.
- R2: Mode word 00,1,r,0 decodes to class code 1 (reduce), with reverse_o = bit 1. Mode word 00,1,x,1 raises illegal_o. For that word no element is issued and done_o is high in the first cycle after start.
- R3: Mode word 10,n,d,s decodes to class code 2 (saturate), with sat_signed_o = n (0 unsigned, 1 signed), dz_o = bit 1 and sz_o = bit 0.
- R4: Any word with bit 3 = 1 decodes to class code 3 (fail-first), with ff_incl_o = bit 4 and ff_inv_o = bit 2. With rc_i = 1, ff_crsel_o = bits [1:0] and dz_o = sz_o = 0. With rc_i = 0, dz_o = sz_o = bit 1, ff_rc1_o = bit 0 and ff_crsel_o = 0.
- R5: With reverse clear, element k (counting from 0) is presented in cycle k+1 after start, with index k. Indices step by +1 each cycle. done_o follows in the cycle after the final element.
- R6: With reverse set, indices are presented from VL-1 down to 0, stepping by -1 each cycle.
- R7: When predication is enabled and an element's mask bit is 0, the element is issued with zero_dst_o = 1 if dz_o is set. If dz_o is clear, the element is skipped (no issue) but still takes its cycle.
- R8: Outside reduce mode with a scalar destination, the loop ends after the first issued element, so exactly one element is issued.
- R9: In reduce mode a scalar destination does not end the loop. chain_o is high on every issued element except the first of the loop.
- R10: With VL = 0, no element is issued and done_o is high in the first cycle after start.
- R11: A stop request seen during a RUN cycle ends the loop after that cycle's element, and done_o follows in the next cycle.
- R12: A start pulse while the loop is running is ignored: the running loop's length and mode are unchanged.
- R13: done_o is high for exactly one cycle per start. The decoded outputs keep the values latched at start through the loop and the done cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted only in IDLE |
| mode_i | input | 5 | Per-instruction mode word |
| rc_i | input | 1 | Result-flag (condition record) bit of the instruction |
| vl_i | input | VLW (7) | Vector length, clamped to MAXVL |
| pred_en_i | input | 1 | Predication enable |
| pred_i | input | MAXVL (64) | Predicate mask, bit i for element i |
| scalar_dst_i | input | 1 | Destination operand is scalar |
| stop_i | input | 1 | External request to end the loop |
| busy_o | output | 1 | Controller is in RUN |
| issue_o | output | 1 | Element issue strobe |
| elem_idx_o | output | IW (6) | Index of the presented element |
| zero_dst_o | output | 1 | Issued element is to be written as zero |
| chain_o | output | 1 | Issued element accumulates onto the previous result |
| done_o | output | 1 | One-cycle end-of-loop pulse |
| mclass_o | output | 2 | Mode class: 0 simple, 1 reduce, 2 saturate, 3 fail-first |
| illegal_o | output | 1 | Reserved mode word |
| dz_o | output | 1 | Destination zeroing |
| sz_o | output | 1 | Source zeroing |
| reverse_o | output | 1 | Descending index order |
| sat_signed_o | output | 1 | Signed saturation |
| ff_incl_o | output | 1 | Fail-first counts the failing element |
| ff_inv_o | output | 1 | Fail-first test polarity |
| ff_crsel_o | output | 2 | Fail-first condition bit select |
| ff_rc1_o | output | 1 | Fail-first zero test without a result-flag bit |

## Verification
The bench targets the loop's ends. A zero length and the reserved mode word must both reach done in one cycle; a design that entered RUN for either would issue element 0 or an out-of-range index. A stop request must cut the loop right after the presented element, and a late stop would leak one more issue. Reverse order starts at VL-1, so an off-by-one load would show index VL or miss element 0. With a scalar destination, a loop that failed to end outside reduce mode would issue extra elements, and one that ended inside reduce mode would lose the accumulation chain. Masked elements are checked both ways: a wrong dz path either drops zero-writes or issues elements that should be skipped. A restart during RUN must not change the length.

// File: rtl/vseq_pkg.sv
package vseq_pkg;

    typedef enum logic [1:0] {
        MC_SIMPLE = 2'd0,
        MC_REDUCE = 2'd1,
        MC_SAT    = 2'd2,
        MC_FFIRST = 2'd3
    } mclass_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

    typedef struct packed {
        mclass_e    mclass;
        logic       illegal;
        logic       dz;
        logic       sz;
        logic       rev;
        logic       sat_signed;
        logic       ff_incl;
        logic       ff_inv;
        logic [1:0] ff_crsel;
        logic       ff_rc1;
    } mode_dec_t;

endpackage

// File: rtl/vseq_mode_dec.sv
module vseq_mode_dec
    import vseq_pkg::*;
(
    input  logic [4:0] mode_i,
    input  logic       rc_i,
    output mode_dec_t  dec_o
);

    always_comb begin
        dec_o = '0;
        unique case (mode_i[4:3])
            2'b00: begin
                if (!mode_i[2]) begin
                    dec_o.mclass = MC_SIMPLE;
                    dec_o.dz     = mode_i[1];
                    dec_o.sz     = mode_i[0];
                end else begin
                    dec_o.mclass  = MC_REDUCE;
                    dec_o.rev     = mode_i[1];
                    dec_o.illegal = mode_i[0];
                end
            end
            2'b10: begin
                dec_o.mclass     = MC_SAT;
                dec_o.sat_signed = mode_i[2];
                dec_o.dz         = mode_i[1];
                dec_o.sz         = mode_i[0];
            end
            2'b01, 2'b11: begin
                dec_o.mclass  = MC_FFIRST;
                dec_o.ff_incl = mode_i[4];
                dec_o.ff_inv  = mode_i[2];
                if (rc_i) begin
                    dec_o.ff_crsel = mode_i[1:0];
                end else begin
                    dec_o.dz     = mode_i[1];
                    dec_o.sz     = mode_i[1];
                    dec_o.ff_rc1 = mode_i[0];
                end
            end
            default: dec_o = '0;
        endcase
    end

    // R2
    always_comb begin
        illegal_only_reduce_chk: assert (!dec_o.illegal || dec_o.mclass == MC_REDUCE);
    end

endmodule

// File: rtl/vseq_idx_walk.sv
module vseq_idx_walk #(
    parameter int MAXVL = 64,
    parameter int IW    = $clog2(MAXVL),
    parameter int VLW   = $clog2(MAXVL + 1)
) (
    input  logic           clk_i,
    input  logic           rst_ni,
    input  logic           load_i,
    input  logic           rev_i,
    input  logic [VLW-1:0] vl_i,
    input  logic           step_i,
    output logic [IW-1:0]  idx_o,
    output logic           last_o
);

    logic [IW-1:0]  idx_q;
    logic [VLW-1:0] left_q;
    logic           rev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            idx_q  <= '0;
            left_q <= '0;
            rev_q  <= 1'b0;
        end else if (load_i) begin
            rev_q  <= rev_i;
            left_q <= vl_i;
            idx_q  <= rev_i ? IW'(vl_i - VLW'(1)) : '0;
        end else if (step_i) begin
            left_q <= left_q - VLW'(1);
            idx_q  <= rev_q ? (idx_q - IW'(1)) : (idx_q + IW'(1));
        end
    end

    assign idx_o  = idx_q;
    assign last_o = (left_q == VLW'(1));

    // R5
    no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i |-> (left_q > VLW'(1)));

endmodule

// File: rtl/vec_elem_seq.sv
module vec_elem_seq
    import vseq_pkg::*;
#(
    parameter int   MAXVL = 64,
    localparam int  IW    = $clog2(MAXVL),
    localparam int  VLW   = $clog2(MAXVL + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic [4:0]       mode_i,
    input  logic             rc_i,
    input  logic [VLW-1:0]   vl_i,
    input  logic             pred_en_i,
    input  logic [MAXVL-1:0] pred_i,
    input  logic             scalar_dst_i,
    input  logic             stop_i,
    output logic             busy_o,
    output logic             issue_o,
    output logic [IW-1:0]    elem_idx_o,
    output logic             zero_dst_o,
    output logic             chain_o,
    output logic             done_o,
    output logic [1:0]       mclass_o,
    output logic             illegal_o,
    output logic             dz_o,
    output logic             sz_o,
    output logic             reverse_o,
    output logic             sat_signed_o,
    output logic             ff_incl_o,
    output logic             ff_inv_o,
    output logic [1:0]       ff_crsel_o,
    output logic             ff_rc1_o
);

    seq_state_e       st_q, st_d;
    mode_dec_t        dec_w, dec_q;
    logic [MAXVL-1:0] pred_q;
    logic             scalar_q;
    logic             any_iss_q;
    logic [VLW-1:0]   vl_eff_w;
    logic             start_ok_w, load_w, step_w, end_w;
    logic             cur_act_w, issue_w;
    logic [IW-1:0]    idx_w;
    logic             last_w;

    vseq_mode_dec u_dec (
        .mode_i (mode_i),
        .rc_i   (rc_i),
        .dec_o  (dec_w)
    );

    assign vl_eff_w   = (vl_i > VLW'(MAXVL)) ? VLW'(MAXVL) : vl_i;
    assign start_ok_w = (st_q == ST_IDLE) && start_i;
    assign load_w     = start_ok_w && (vl_eff_w != '0) && !dec_w.illegal;

    vseq_idx_walk #(.MAXVL(MAXVL), .IW(IW), .VLW(VLW)) u_walk (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .load_i (load_w),
        .rev_i  (dec_w.rev),
        .vl_i   (vl_eff_w),
        .step_i (step_w),
        .idx_o  (idx_w),
        .last_o (last_w)
    );

    assign cur_act_w = pred_q[idx_w];
    assign issue_w   = (st_q == ST_RUN) && (cur_act_w || dec_q.dz);
    assign end_w     = stop_i || last_w
                     || (scalar_q && (dec_q.mclass != MC_REDUCE) && issue_w);
    assign step_w    = (st_q == ST_RUN) && !end_w;

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (start_i) begin
                    st_d = ((vl_eff_w == '0) || dec_w.illegal) ? ST_DONE : ST_RUN;
                end
            end
            ST_RUN: begin
                if (end_w) begin
                    st_d = ST_DONE;
                end
            end
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // context latched at start
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dec_q     <= '0;
            pred_q    <= '0;
            scalar_q  <= 1'b0;
            any_iss_q <= 1'b0;
        end else if (start_ok_w) begin
            dec_q     <= dec_w;
            pred_q    <= pred_en_i ? pred_i : '1;
            scalar_q  <= scalar_dst_i;
            any_iss_q <= 1'b0;
        end else if (issue_w) begin
            any_iss_q <= 1'b1;
        end
    end

    // outputs
    always_comb begin
        busy_o       = (st_q == ST_RUN);
        done_o       = (st_q == ST_DONE);
        issue_o      = issue_w;
        elem_idx_o   = idx_w;
        zero_dst_o   = issue_w && !cur_act_w;
        chain_o      = issue_w && (dec_q.mclass == MC_REDUCE) && any_iss_q;
        mclass_o     = dec_q.mclass;
        illegal_o    = dec_q.illegal;
        dz_o         = dec_q.dz;
        sz_o         = dec_q.sz;
        reverse_o    = dec_q.rev;
        sat_signed_o = dec_q.sat_signed;
        ff_incl_o    = dec_q.ff_incl;
        ff_inv_o     = dec_q.ff_inv;
        ff_crsel_o   = dec_q.ff_crsel;
        ff_rc1_o     = dec_q.ff_rc1;
    end

    // R5
    issue_in_run_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        issue_o |-> busy_o);

    // R5
    fwd_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o) && !reverse_o) |-> (elem_idx_o == $past(elem_idx_o) + IW'(1)));

    // R6
    rev_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && $past(busy_o) && reverse_o) |-> (elem_idx_o == $past(elem_idx_o) - IW'(1)));

    // R7
    zero_needs_dz_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        zero_dst_o |-> (issue_o && dz_o));

    // R9
    chain_reduce_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        chain_o |-> (issue_o && mclass_o == 2'd1));

    // R2
    illegal_no_issue_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        illegal_o |-> !issue_o);

    // R10
    vl_zero_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q == ST_IDLE && start_i && vl_i == '0) |=> (done_o && !issue_o));

    // R11
    stop_ends_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && stop_i) |=> done_o);

    // R13
    done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

endmodule

// File: tb/vec_elem_seq_tb_top.sv
module vec_elem_seq_tb_top;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        start_i = 1'b0;
    logic [4:0]  mode_i = '0;
    logic        rc_i = 1'b0;
    logic [6:0]  vl_i = '0;
    logic        pred_en_i = 1'b0;
    logic [63:0] pred_i = '0;
    logic        scalar_dst_i = 1'b0;
    logic        stop_i = 1'b0;
    logic        busy_o, issue_o, zero_dst_o, chain_o, done_o;
    logic [5:0]  elem_idx_o;
    logic [1:0]  mclass_o, ff_crsel_o;
    logic        illegal_o, dz_o, sz_o, reverse_o, sat_signed_o;
    logic        ff_incl_o, ff_inv_o, ff_rc1_o;

    int n_chk = 0;
    int n_bad = 0;

    int g_n, g_done, g_extra;
    int g_idx[64];
    int g_zero[64];
    int g_chain[64];
    int c1_cls, cd_cls, cd_ill, cd_dz, cd_sz, cd_rev, cd_sgn, cd_inc, cd_inv, cd_sel, cd_rc1;
    int e_n, e_done;
    int e_idx[64];
    int e_zero[64];
    int e_chain[64];

    always #4 clk_i = ~clk_i;

    vec_elem_seq dut_i (
        .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i), .mode_i(mode_i), .rc_i(rc_i),
        .vl_i(vl_i), .pred_en_i(pred_en_i), .pred_i(pred_i), .scalar_dst_i(scalar_dst_i),
        .stop_i(stop_i), .busy_o(busy_o), .issue_o(issue_o), .elem_idx_o(elem_idx_o),
        .zero_dst_o(zero_dst_o), .chain_o(chain_o), .done_o(done_o), .mclass_o(mclass_o),
        .illegal_o(illegal_o), .dz_o(dz_o), .sz_o(sz_o), .reverse_o(reverse_o),
        .sat_signed_o(sat_signed_o), .ff_incl_o(ff_incl_o), .ff_inv_o(ff_inv_o),
        .ff_crsel_o(ff_crsel_o), .ff_rc1_o(ff_rc1_o)
    );

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic run_loop(input logic [4:0] m, input logic rc, input int vl,
                            input logic [63:0] pr, input logic pen, input logic sd,
                            input int stop_cyc, input int rs_cyc);
        int cyc = 0;
        bit fin = 0;
        @(negedge clk_i);
        mode_i = m; rc_i = rc; vl_i = 7'(vl); pred_i = pr; pred_en_i = pen;
        scalar_dst_i = sd; start_i = 1'b1;
        @(negedge clk_i);
        start_i = 1'b0;
        g_n = 0; g_done = -1;
        while (!fin && cyc < 200) begin
            cyc++;
            if (cyc == 1) c1_cls = int'(mclass_o);
            if (issue_o) begin
                g_idx[g_n] = int'(elem_idx_o);
                g_zero[g_n] = int'(zero_dst_o);
                g_chain[g_n] = int'(chain_o);
                g_n++;
            end
            if (done_o) begin
                fin = 1; g_done = cyc;
                cd_cls = int'(mclass_o); cd_ill = int'(illegal_o); cd_dz = int'(dz_o);
                cd_sz = int'(sz_o); cd_rev = int'(reverse_o); cd_sgn = int'(sat_signed_o);
                cd_inc = int'(ff_incl_o); cd_inv = int'(ff_inv_o);
                cd_sel = int'(ff_crsel_o); cd_rc1 = int'(ff_rc1_o);
            end
            stop_i = (cyc == stop_cyc);
            start_i = (cyc == rs_cyc);
            if (cyc == rs_cyc) vl_i = 7'(vl + 6);
            @(negedge clk_i);
        end
        stop_i = 1'b0; start_i = 1'b0;
        g_extra = int'(done_o);
    endtask

    task automatic model(input bit rev, input bit dz, input bit red, input bit sd, input int vl,
                         input logic [63:0] pr, input bit pen, input int stop_cyc);
        e_n = 0; e_done = 1;
        for (int k = 0; k < vl; k++) begin
            int ix;
            bit act;
            ix = rev ? (vl - 1 - k) : k;
            act = !pen || pr[ix];
            e_done = k + 2;
            if (act || dz) begin
                e_idx[e_n] = ix; e_zero[e_n] = int'(!act); e_chain[e_n] = int'(red && e_n > 0);
                e_n++;
                if (sd && !red) break;
            end
            if (k + 1 == stop_cyc) break;
        end
    endtask

    task automatic cmp(input string rq);
        chk(rq, "issued count", g_n, e_n);
        for (int i = 0; i < e_n && i < g_n; i++) begin
            chk(rq, "element index", g_idx[i], e_idx[i]);
            chk(rq, "zero flag", g_zero[i], e_zero[i]);
            chk(rq, "chain flag", g_chain[i], e_chain[i]);
        end
        chk(rq, "done cycle", g_done, e_done);
        chk("R13", "second done pulse", g_extra, 0);
        chk("R13", "class held", cd_cls, c1_cls);
    endtask

    task automatic t_reset();
        chk("R13", "busy after reset", int'(busy_o), 0);
        chk("R13", "issue after reset", int'(issue_o), 0);
        chk("R13", "done after reset", int'(done_o), 0);
    endtask

    task automatic t_simple_fwd();
        run_loop(5'b00010, 1'b0, 5, '1, 1'b0, 1'b0, 0, 0);
        model(0, 1, 0, 0, 5, '1, 0, 0);
        cmp("R5");
        chk("R1", "class", cd_cls, 0);
        chk("R1", "dz", cd_dz, 1);
        chk("R1", "sz", cd_sz, 0);
    endtask

    task automatic t_reduce_rev();
        run_loop(5'b00110, 1'b0, 6, '1, 1'b0, 1'b0, 0, 0);
        model(1, 0, 1, 0, 6, '1, 0, 0);
        cmp("R6");
        chk("R2", "class reduce", cd_cls, 1);
        chk("R2", "reverse", cd_rev, 1);
    endtask

    task automatic t_reduce_scalar();
        run_loop(5'b00100, 1'b0, 4, '1, 1'b0, 1'b1, 0, 0);
        model(0, 0, 1, 1, 4, '1, 0, 0);
        cmp("R9");
        chk("R9", "reverse clear", cd_rev, 0);
    endtask

    task automatic t_reserved();
        run_loop(5'b00101, 1'b0, 8, '1, 1'b0, 1'b0, 0, 0);
        model(0, 0, 0, 0, 0, '1, 0, 0);
        cmp("R2");
        chk("R2", "illegal", cd_ill, 1);
    endtask

    task automatic t_sat_zero();
        run_loop(5'b10110, 1'b0, 4, 64'b0101, 1'b1, 1'b0, 0, 0);
        model(0, 1, 0, 0, 4, 64'b0101, 1, 0);
        cmp("R7");
        chk("R3", "class sat", cd_cls, 2);
        chk("R3", "signed", cd_sgn, 1);
        chk("R3", "dz", cd_dz, 1);
        chk("R3", "sz", cd_sz, 0);
        run_loop(5'b10001, 1'b0, 2, '1, 1'b0, 1'b0, 0, 0);
        chk("R3", "unsigned", cd_sgn, 0);
        chk("R3", "sz set", cd_sz, 1);
    endtask

    task automatic t_pred_skip();
        run_loop(5'b00001, 1'b0, 4, 64'b1001, 1'b1, 1'b0, 0, 0);
        model(0, 0, 0, 0, 4, 64'b1001, 1, 0);
        cmp("R7");
    endtask

    task automatic t_ff_decode();
        run_loop(5'b11110, 1'b1, 3, '1, 1'b0, 1'b0, 0, 0);
        model(0, 0, 0, 0, 3, '1, 0, 0);
        cmp("R4");
        chk("R4", "class ff", cd_cls, 3);
        chk("R4", "incl", cd_inc, 1);
        chk("R4", "inv", cd_inv, 1);
        chk("R4", "crsel", cd_sel, 2);
        chk("R4", "dz with rc", cd_dz, 0);
        run_loop(5'b01011, 1'b0, 3, '1, 1'b0, 1'b0, 0, 0);
        chk("R4", "incl clear", cd_inc, 0);
        chk("R4", "inv clear", cd_inv, 0);
        chk("R4", "zz dz", cd_dz, 1);
        chk("R4", "zz sz", cd_sz, 1);
        chk("R4", "rc1", cd_rc1, 1);
        chk("R4", "crsel without rc", cd_sel, 0);
    endtask

    task automatic t_scalar_simple();
        run_loop(5'b00000, 1'b0, 5, 64'b11100, 1'b1, 1'b1, 0, 0);
        model(0, 0, 0, 1, 5, 64'b11100, 1, 0);
        cmp("R8");
    endtask

    task automatic t_vl_zero();
        run_loop(5'b00000, 1'b0, 0, '1, 1'b0, 1'b0, 0, 0);
        model(0, 0, 0, 0, 0, '1, 0, 0);
        cmp("R10");
    endtask

    task automatic t_stop();
        run_loop(5'b00000, 1'b0, 10, '1, 1'b0, 1'b0, 3, 0);
        model(0, 0, 0, 0, 10, '1, 0, 3);
        cmp("R11");
    endtask

    task automatic t_restart();
        run_loop(5'b00000, 1'b0, 4, '1, 1'b0, 1'b0, 0, 2);
        model(0, 0, 0, 0, 4, '1, 0, 0);
        cmp("R12");
        @(negedge clk_i);
        chk("R12", "no loop from ignored start", int'(busy_o), 0);
    endtask

    initial begin
        #(8 * 150000);
        n_chk++; n_bad++;
        $display("FAIL R5 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        t_reset();
        rst_ni = 1'b1;
        @(negedge clk_i);
        t_reset();
        t_simple_fwd();
        t_reduce_rev();
        t_reduce_scalar();
        t_reserved();
        t_sat_zero();
        t_pred_skip();
        t_ff_decode();
        t_scalar_simple();
        t_vl_zero();
        t_stop();
        t_restart();
        repeat (2) @(negedge clk_i);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule